// File: doc/BRIEF.md
# Address-Pointer Write-Use Interlock

This unit decides when an in-order DSP pipeline must hold its front end because the instruction in the address-generation stage wants a pointer register that an older instruction has not yet written. A pointer loaded from memory or from a data-ALU register gets its value only at the end of the execute stage. The address-generation stage, however, reads pointers several cycles earlier. The unit keeps its own record of the write masks of the instructions that have left address generation. Each cycle it ANDs those masks with the read mask of the instruction now in address generation.

The interlock is selective. Immediate loads and pointer-to-pointer transfers settle early enough that they never stall. The unit also leaves writes to the modifier register, to the third offset register, and bit-manipulation writes to the main offset register unprotected, so a consumer of those registers reads the old value. When a hazard is found, fetch, decode and address generation hold, and a NOP with valid low enters the next stage. A taken-branch flush empties the record and cancels any stall in the same cycle.

Top module: `agu_hazard_ctl`

## Requirements
- R1: After reset, no producer is pending, so a valid instruction in address generation that reads any register does not stall.
- R2: A data move (source kind 3) that writes a protected pointer (mask bits 0–5 for R0–R5, bit 6 for N, bit 7 for SP) stalls a reader of that register for exactly 2 cycles when the reader directly follows it. With one unrelated instruction between them, the stall lasts exactly 1 cycle.
- R3: An immediate load (source kind 1) never causes a stall, even when the next instruction reads the same register.
- R4: A register-to-register transfer (source kind 2) never causes a stall for a reader of its destination.
- R5: A write to N3 (mask bit 8) or M01 (mask bit 9) by a data move or a bit-manipulation instruction (source kind 4) never causes a stall.
- R6: A bit-manipulation write to N (bit 6) never causes a stall. A bit-manipulation write to a pointer R0–R5 stalls a directly following reader for 2 cycles.
- R7: During a stall, `bubble` equals `stall`, and in the next cycle the stage after address generation holds a descriptor with valid low (`op2_valid` = 0). A valid instruction that advances with no stall shows `op2_valid` = 1 in the next cycle.
- R8: When `flush` is high, `stall` is low in that cycle, and every pending producer is cleared, so a reader in the next cycle does not stall.
- R9: A stall occurs only when the read mask overlaps a pending protected write mask. A data move to R0 followed by a reader of R1 only does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Taken-branch flush; clears pending producers, overrides stall |
| ag_valid | input | 1 | Address-generation stage holds a real instruction |
| ag_src | input | 3 | Write source kind: 0 none, 1 immediate, 2 transfer, 3 data move, 4 bit-manipulation |
| ag_wr_mask | input | 16 | One-hot-per-register write mask of the address-generation instruction |
| ag_rd_mask | input | 16 | Registers read for address calculation by the address-generation instruction |
| stall | output | 1 | Hold fetch, decode and address generation this cycle |
| bubble | output | 1 | Insert a NOP into the stage after address generation this cycle |
| op2_valid | output | 1 | Valid bit of the descriptor now in the stage after address generation |

## Verification
The assertions assume that the stage latches hold the address-generation descriptor steady while `stall` is high, and that an unused source kind (5–7) never comes with a valid instruction. The bench drives each descriptor at the falling edge and keeps it unchanged until it sees `stall` low. Between sequences it drains the pipeline with invalid slots, and it uses only the five defined source kinds. With that, the stall run can never exceed the depth of the pending window, and the number of stall cycles in each sequence matches a known value.

// File: rtl/agu_hz_pkg.sv
// Shared definitions for the pointer write-use interlock.
// Assumes a 16-entry register mask with pointers in the low bits.
package agu_hz_pkg;
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_IMM   = 3'd1,
        SRC_XFER  = 3'd2,
        SRC_MOVE  = 3'd3,
        SRC_BITOP = 3'd4
    } src_kind_e;

    localparam int NUM_PTR = 8;   // R0..R5, N, SP occupy bits 0..7
    localparam int IDX_N   = 6;
    localparam int IDX_N3  = 8;
    localparam int IDX_M01 = 9;
endpackage

// File: rtl/agu_wr_filter.sv
// Reduces an address-generation write mask to the bits the hardware protects.
// Exempt sources (none, immediate, transfer) give an empty mask. N3/M01 are
// never protected, and a bit-manipulation write to N is dropped.
module agu_wr_filter
    import agu_hz_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic            valid_i,
    input  logic [2:0]      src_i,
    input  logic [NREG-1:0] wr_mask_i,
    output logic [NREG-1:0] prot_mask_o
);
    localparam logic [NREG-1:0] PTR_MASK = {{(NREG-NUM_PTR){1'b0}}, {NUM_PTR{1'b1}}};
    localparam logic [NREG-1:0] N_BIT    = NREG'(1) << IDX_N;

    // Pick the protected subset of the write mask according to the source kind.
    always_comb begin
        prot_mask_o = '0;
        if (valid_i) begin
            unique case (src_kind_e'(src_i))
                SRC_MOVE:  prot_mask_o = wr_mask_i & PTR_MASK;
                SRC_BITOP: prot_mask_o = wr_mask_i & PTR_MASK & ~N_BIT;
                default:   prot_mask_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/agu_prod_track.sv
// Shift record of protected write masks for instructions that left address
// generation and have not yet written back. Entry 0 is the stage after
// address generation; the last entry is execute. A stall shifts in an empty
// mask (the bubble); a flush empties every entry.
module agu_prod_track
    import agu_hz_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int PEND_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush_i,
    input  logic                              stall_i,
    input  logic [NREG-1:0]                   new_mask_i,
    output logic [PEND_STAGES-1:0][NREG-1:0]  pend_o
);
    localparam logic [NREG-1:0] PTR_MASK = {{(NREG-NUM_PTR){1'b0}}, {NUM_PTR{1'b1}}};

    logic [PEND_STAGES-1:0][NREG-1:0] pend_q;

    // Advance the record one stage per cycle, with a bubble on stall.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            pend_q <= '0;
        end else begin
            pend_q[0] <= stall_i ? '0 : new_mask_i;
            for (int k = 1; k < PEND_STAGES; k++) begin
                pend_q[k] <= pend_q[k-1];
            end
        end
    end

    assign pend_o = pend_q;

    // R5: modifier and N3 bits never enter the record.
    generate
        for (genvar g = 0; g < PEND_STAGES; g++) begin : g_chk
            p_unprot_never_tracked_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[g] & ~PTR_MASK) == '0);
        end
    endgenerate

    // R8: a flush leaves the record empty in the next cycle.
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pend_q == '0));
endmodule

// File: rtl/agu_hazard_cmp.sv
// Compares the address-generation read mask with every pending protected
// write mask; reports whether any register overlaps.
module agu_hazard_cmp #(
    parameter int NREG        = 16,
    parameter int PEND_STAGES = 2
) (
    input  logic [PEND_STAGES-1:0][NREG-1:0] pend_i,
    input  logic [NREG-1:0]                  rd_mask_i,
    output logic                             hit_o
);
    logic [PEND_STAGES-1:0] stage_hit;

    // One overlap detector per pending stage.
    generate
        for (genvar g = 0; g < PEND_STAGES; g++) begin : g_cmp
            assign stage_hit[g] = |(pend_i[g] & rd_mask_i);
        end
    endgenerate

    assign hit_o = |stage_hit;
endmodule

// File: rtl/agu_hazard_ctl.sv
// Top of the pointer write-use interlock. Filters the address-generation
// write mask, tracks pending producers, and raises stall/bubble when the
// current reader overlaps a pending protected write. Flush wins over stall.
// Assumes the stage latches hold the descriptor steady while stall is high.
module agu_hazard_ctl
    import agu_hz_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int PEND_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            ag_valid,
    input  logic [2:0]      ag_src,
    input  logic [NREG-1:0] ag_wr_mask,
    input  logic [NREG-1:0] ag_rd_mask,
    output logic            stall,
    output logic            bubble,
    output logic            op2_valid
);
    localparam int CW = $clog2(PEND_STAGES + 2);

    logic [NREG-1:0]                  prot_mask;
    logic [PEND_STAGES-1:0][NREG-1:0] pend;
    logic                             hit;
    logic                             op2_valid_q;
    logic [CW-1:0]                    run_cnt;

    agu_wr_filter #(.NREG(NREG)) u_filter (
        .valid_i     (ag_valid),
        .src_i       (ag_src),
        .wr_mask_i   (ag_wr_mask),
        .prot_mask_o (prot_mask)
    );

    agu_prod_track #(.NREG(NREG), .PEND_STAGES(PEND_STAGES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .stall_i    (stall),
        .new_mask_i (prot_mask),
        .pend_o     (pend)
    );

    agu_hazard_cmp #(.NREG(NREG), .PEND_STAGES(PEND_STAGES)) u_cmp (
        .pend_i    (pend),
        .rd_mask_i (ag_rd_mask),
        .hit_o     (hit)
    );

    assign stall  = ag_valid && hit && !flush;
    assign bubble = stall;

    // Valid bit of the descriptor entering the stage after address generation.
    always_ff @(posedge clk) begin
        if (!rst_n) op2_valid_q <= 1'b0;
        else        op2_valid_q <= ag_valid && !stall;
    end
    assign op2_valid = op2_valid_q;

    // Length of the current run of stall cycles, for the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_cnt <= '0;
        else if (stall) run_cnt <= run_cnt + 1'b1;
        else            run_cnt <= '0;
    end

    // R8: flush overrides any stall in the same cycle.
    p_flush_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !stall);

    // R7: a stall cycle puts an invalid descriptor into the next stage.
    p_bubble_after_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !op2_valid);

    // R2: a held reader never waits longer than the pending window.
    p_stall_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(PEND_STAGES));

    // R9: no stall without a valid reader.
    p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ag_valid |-> !stall);
endmodule

// File: tb/agu_hazard_ctl_tb.sv
module agu_hazard_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        ag_valid = 1'b0;
    logic [2:0]  ag_src = 3'd0;
    logic [15:0] ag_wr_mask = '0;
    logic [15:0] ag_rd_mask = '0;
    logic        stall, bubble, op2_valid;

    int errors = 0;
    int checks = 0;
    int seq_stalls = 0;
    bit finished = 1'b0;
    int exp_q[$];
    int act_q[$];
    string tag_q[$];

    localparam logic [2:0] K_NONE = 3'd0, K_IMM = 3'd1, K_XFER = 3'd2,
                           K_MOVE = 3'd3, K_BIT = 3'd4;
    localparam logic [15:0] M_R0 = 16'h0001, M_R1 = 16'h0002, M_N = 16'h0040,
                            M_SP = 16'h0080, M_N3 = 16'h0100, M_M01 = 16'h0200;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_hazard_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ag_valid(ag_valid),
        .ag_src(ag_src), .ag_wr_mask(ag_wr_mask), .ag_rd_mask(ag_rd_mask),
        .stall(stall), .bubble(bubble), .op2_valid(op2_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: present one instruction and hold it until it is accepted.
    task automatic issue(input logic [2:0] k, input logic [15:0] wr, input logic [15:0] rd);
        @(negedge clk);
        ag_valid = 1'b1; ag_src = k; ag_wr_mask = wr; ag_rd_mask = rd;
        #1;
        while (stall) begin
            seq_stalls++;
            check("R7 bubble equals stall", int'(bubble), 1);
            @(negedge clk); #1;
            check("R7 invalid descriptor after stall", int'(op2_valid), 0);
        end
    endtask

    task automatic drain();
        repeat (3) begin
            @(negedge clk);
            ag_valid = 1'b0; ag_src = K_NONE; ag_wr_mask = '0; ag_rd_mask = '0;
        end
    endtask

    task automatic begin_seq(input string tag, input int exp_stalls);
        seq_stalls = 0;
        exp_q.push_back(exp_stalls);
        tag_q.push_back(tag);
    endtask

    task automatic end_seq();
        drain();
        act_q.push_back(seq_stalls);
    endtask

    // Monitor: compare finished sequences against their expected stall counts.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing pending after reset.
        @(negedge clk);
        ag_valid = 1'b1; ag_src = K_NONE; ag_rd_mask = 16'hFFFF; #1;
        check("R1 no stall after reset", int'(stall), 0);
        check("R1 bubble low after reset", int'(bubble), 0);
        drain();

        begin_seq("R2 move then adjacent use stalls 2", 2);
        issue(K_MOVE, M_R0, '0); issue(K_NONE, '0, M_R0); end_seq();

        begin_seq("R2 move, gap, use stalls 1", 1);
        issue(K_MOVE, M_SP, '0); issue(K_NONE, '0, '0); issue(K_NONE, '0, M_SP); end_seq();

        begin_seq("R3 immediate then use no stall", 0);
        issue(K_IMM, M_R0, '0); issue(K_NONE, '0, M_R0); end_seq();

        begin_seq("R4 transfer then use no stall", 0);
        issue(K_XFER, M_R1, M_R0); issue(K_NONE, '0, M_R1); end_seq();

        begin_seq("R5 move to M01 then use no stall", 0);
        issue(K_MOVE, M_M01, '0); issue(K_NONE, '0, M_M01 | M_R0); end_seq();

        begin_seq("R5 bitop to N3 then use no stall", 0);
        issue(K_BIT, M_N3, '0); issue(K_NONE, '0, M_N3); end_seq();

        begin_seq("R6 bitop to N then use no stall", 0);
        issue(K_BIT, M_N, '0); issue(K_NONE, '0, M_N); end_seq();

        begin_seq("R6 bitop to R1 then use stalls 2", 2);
        issue(K_BIT, M_R1, '0); issue(K_NONE, '0, M_R1); end_seq();

        begin_seq("R9 move R0, read R1 no stall", 0);
        issue(K_MOVE, M_R0, '0); issue(K_NONE, '0, M_R1); end_seq();

        // R7: advancing valid instruction shows valid next stage.
        @(negedge clk);
        ag_valid = 1'b1; ag_src = K_NONE; ag_wr_mask = '0; ag_rd_mask = '0;
        @(negedge clk); #1;
        check("R7 op2 valid after advance", int'(op2_valid), 1);
        drain();

        // R8: flush during a would-be stall, then pending record empty.
        @(negedge clk);
        ag_valid = 1'b1; ag_src = K_MOVE; ag_wr_mask = M_R0; ag_rd_mask = '0;
        @(negedge clk);
        ag_src = K_NONE; ag_wr_mask = '0; ag_rd_mask = M_R0; flush = 1'b1; #1;
        check("R8 flush overrides stall", int'(stall), 0);
        @(negedge clk);
        flush = 1'b0; #1;
        check("R8 pending cleared by flush", int'(stall), 0);
        drain();

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size() + act_q.size(), 0);
        report();
    end
endmodule